// File: doc/BRIEF.md
# Multi-Stage Write-Coherency Semaphore Tracker

This block keeps per-stage ordering state for a five-stage in-order geometry pipeline (vertex, hull, domain, geometry, pixel). Each draw command names the stages that perform unordered memory writes. For every draw it accepts, the tracker raises a semaphore in each stage that has such a stage at or below it. When the most downstream flagged stage reports that it has finished the draw, the tracker queues one cache flush toward the data cache. When that flush is acknowledged, the flushing stage and every stage above it give their count back.

A draw can also demand strict ordering. The tracker then refuses the command and raises a hold toward the first flagged stage until that stage's semaphore has drained to zero. Without the ordering demand, counting and flushing still happen, but nothing is held. Each completion of a flagged draw produces its own flush, even when completions arrive on back-to-back cycles. No stage is ever left waiting for an acknowledgement that cannot come.

Top module: `coh_sem_tracker`

## Requirements
- R1: After a synchronous active-high reset, every semaphore reads 0, `flush_valid` and `err_o` are 0, `hold_o` is 0 and `cmd_ready` is 1 while no command is offered.
- R2: In the cycle after a draw is accepted, the semaphore of stage s (bit s of the flag vector; bit 0 vertex up to bit 4 pixel) has risen by one exactly when some flag at bit s or above is set.
- R3: An accepted draw with all five flags clear changes no semaphore and never leads to a flush, whatever completion pulses follow.
- R4: A completion pulse on `stage_done` at the highest flagged stage of the oldest pending draw queues one flush. `flush_valid` is high in the next cycle with `flush_stage` equal to that stage index (0 to 4). Completion pulses on any other stage are ignored.
- R5: An acknowledgement pulse on `flush_ack` retires the oldest issued flush and lowers by one the semaphores of its stage and of every lower-numbered stage, in the following cycle.
- R6: Completions arriving on consecutive cycles for consecutive pending draws each produce their own flush, so both flushes become visible on `flush_valid` in turn.
- R7: A command offered with the ordering bit set and at least one flag is held while the semaphore of its lowest-numbered flagged stage is nonzero. During that time `cmd_ready` is 0 and `hold_o` is one-hot at that stage. With the ordering bit clear, no hold is raised.
- R8: At most MAX_OUT (default 4) flagged draws and flushes are in flight together. At that limit `cmd_ready` is 0 for a flagged command.
- R9: An acknowledgement with no issued, unacknowledged flush, or a semaphore step past its range, sets `err_o`. The flag stays set until reset.
- R10: Flushes leave in completion order. While `flush_valid` is high and `flush_ready` low, both `flush_valid` and `flush_stage` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Draw command offered |
| cmd_ready | output | 1 | Draw command taken this cycle when valid |
| cmd_uav | input | 5 | Per-stage unordered-write flags, bit 0 vertex up to bit 4 pixel |
| cmd_coh | input | 1 | Draw demands strict ordering |
| stage_done | input | 5 | One-cycle completion pulse per stage |
| hold_o | output | 5 | Dispatch hold, one-hot at the held stage |
| flush_valid | output | 1 | Flush request pending |
| flush_ready | input | 1 | Cache takes the flush request |
| flush_stage | output | 3 | Stage index that issued the pending flush |
| flush_ack | input | 1 | One-cycle flush acknowledgement, in request order |
| sem_o | output | 5*CNT_W | Semaphores, stage s at bits [s*CNT_W +: CNT_W] |
| err_o | output | 1 | Sticky error flag |

## Verification
A corrupted semaphore shows up on `sem_o` one cycle after the accept or acknowledgement that touched it. It also shows up later as a wrong hold on the next ordered draw, because the hold decision reads that count directly. A lost or mis-ordered entry in the pending-draw or flush queue shows up on `flush_valid` and `flush_stage` one cycle after the completion pulse. It also leaves a semaphore that never returns to zero after all acknowledgements have been given. Bookkeeping that wrongly counts unflagged draws blocks `cmd_ready` at the occupancy limit earlier than expected.

// File: rtl/coh_pkg.sv
package coh_pkg;

   localparam int NSTAGE = 5;
   localparam int SIDX_W = 3;

   typedef enum logic [SIDX_W-1:0] {
      ST_VERTEX = 3'd0,
      ST_HULL   = 3'd1,
      ST_DOMAIN = 3'd2,
      ST_GEOM   = 3'd3,
      ST_PIXEL  = 3'd4
   } stage_e;

   // index of the most downstream set flag (0 when none)
   function automatic logic [SIDX_W-1:0] last_flag(input logic [NSTAGE-1:0] f);
      logic [SIDX_W-1:0] r;
      r = '0;
      for (int i = 0; i < NSTAGE; i++)
         if (f[i]) r = SIDX_W'(i);
      return r;
   endfunction

   // index of the most upstream set flag (0 when none)
   function automatic logic [SIDX_W-1:0] first_flag(input logic [NSTAGE-1:0] f);
      logic [SIDX_W-1:0] r;
      r = '0;
      for (int i = NSTAGE-1; i >= 0; i--)
         if (f[i]) r = SIDX_W'(i);
      return r;
   endfunction

endpackage

// File: rtl/coh_fifo.sv
module coh_fifo #(
   parameter int W     = 3,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("coh_fifo: DEPTH must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_p, rd_p, wr_n, rd_n;

   if ((DEPTH & (DEPTH - 1)) == 0 && DEPTH > 1) begin : g_pow2
      assign wr_n = wr_p + 1'b1;
      assign rd_n = rd_p + 1'b1;
   end else begin : g_wrap
      assign wr_n = (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      assign rd_n = (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
   end

   assign empty = (count == '0);
   assign dout  = mem[rd_p];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_p  <= '0;
         rd_p  <= '0;
         count <= '0;
      end else begin
         if (push) begin
            mem[wr_p] <= din;
            wr_p      <= wr_n;
         end
         if (pop) rd_p <= rd_n;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      push && !pop |-> count < CW'(DEPTH)); // R8
   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty); // R4

endmodule

// File: rtl/coh_flush_queue.sv
module coh_flush_queue #(
   parameter int DEPTH = 4,
   parameter int SW    = 3,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [SW-1:0] push_stage,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [SW-1:0] out_stage,
   input  logic          ack,
   output logic          ack_take,
   output logic [SW-1:0] ack_stage,
   output logic [CW-1:0] count
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("coh_flush_queue: DEPTH must be at least 1");
   end

   logic [SW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_p, is_p, rd_p, wr_n, is_n, rd_n;
   logic [CW-1:0] in_air;   // issued, not yet acknowledged
   logic          issue;

   if ((DEPTH & (DEPTH - 1)) == 0 && DEPTH > 1) begin : g_pow2
      assign wr_n = wr_p + 1'b1;
      assign is_n = is_p + 1'b1;
      assign rd_n = rd_p + 1'b1;
   end else begin : g_wrap
      assign wr_n = (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      assign is_n = (is_p == PW'(DEPTH - 1)) ? '0 : is_p + 1'b1;
      assign rd_n = (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
   end

   assign out_valid = (count != in_air);
   assign out_stage = mem[is_p];
   assign issue     = out_valid && out_ready;
   assign ack_take  = ack && (in_air != '0);
   assign ack_stage = mem[rd_p];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_p   <= '0;
         is_p   <= '0;
         rd_p   <= '0;
         count  <= '0;
         in_air <= '0;
      end else begin
         if (push) begin
            mem[wr_p] <= push_stage;
            wr_p      <= wr_n;
         end
         if (issue)    is_p <= is_n;
         if (ack_take) rd_p <= rd_n;
         count  <= count + CW'(push) - CW'(ack_take);
         in_air <= in_air + CW'(issue) - CW'(ack_take);
      end
   end

   AST_FQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      count <= CW'(DEPTH)); // R8
   AST_FQ_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_stage)); // R10
   AST_FQ_AIR_BOUND: assert property (@(posedge clk) disable iff (rst)
      in_air <= count); // R5

endmodule

// File: rtl/coh_sem_cell.sv
module coh_sem_cell #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         ovf,
   output logic         unf
);

   if (W < 2) begin : g_bad_w
      $error("coh_sem_cell: W must be at least 2");
   end

   always_comb begin
      ovf = inc && !dec && (cnt == '1);
      unf = dec && !inc && (cnt == '0);
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (inc && !dec && !ovf)
         cnt <= cnt + 1'b1;
      else if (dec && !inc && !unf)
         cnt <= cnt - 1'b1;
   end

   AST_SEM_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      dec && !inc |-> cnt != '0); // R5
   AST_SEM_STEP: assert property (@(posedge clk) disable iff (rst)
      inc && !dec && !ovf |=> cnt == $past(cnt) + 1'b1); // R2

endmodule

// File: rtl/coh_sem_tracker.sv
module coh_sem_tracker
   import coh_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int MAX_OUT = 4,
   localparam int OCW    = $clog2(MAX_OUT + 1),
   localparam int OSW    = OCW + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cmd_valid,
   output logic                    cmd_ready,
   input  logic [NSTAGE-1:0]       cmd_uav,
   input  logic                    cmd_coh,
   input  logic [NSTAGE-1:0]       stage_done,
   output logic [NSTAGE-1:0]       hold_o,
   output logic                    flush_valid,
   input  logic                    flush_ready,
   output logic [SIDX_W-1:0]       flush_stage,
   input  logic                    flush_ack,
   output logic [NSTAGE*CNT_W-1:0] sem_o,
   output logic                    err_o
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("coh_sem_tracker: CNT_W must be at least 2");
   end
   if (MAX_OUT < 1) begin : g_bad_max
      $error("coh_sem_tracker: MAX_OUT must be at least 1");
   end
   if ((2 ** CNT_W) - 1 < MAX_OUT) begin : g_bad_range
      $error("coh_sem_tracker: CNT_W cannot hold MAX_OUT");
   end

   logic [CNT_W-1:0]  sem [NSTAGE];
   logic [NSTAGE-1:0] inc_v, dec_v, ovf_v, unf_v;

   logic              any_flag, want_hold, room, accept;
   logic [SIDX_W-1:0] first_idx, last_idx;
   logic [OCW-1:0]    draw_cnt, fq_cnt;
   logic [OSW-1:0]    occ;
   logic              draw_empty, done_hit;
   logic [SIDX_W-1:0] head_stage;
   logic              ack_take;
   logic [SIDX_W-1:0] ack_stage;
   logic              spurious;

   // ---------------- command admission and dispatch hold ----------------
   assign any_flag  = |cmd_uav;
   assign first_idx = first_flag(cmd_uav);
   assign last_idx  = last_flag(cmd_uav);
   assign want_hold = cmd_valid && cmd_coh && any_flag && (sem[first_idx] != '0);
   assign occ       = OSW'(draw_cnt) + OSW'(fq_cnt);
   assign room      = occ < OSW'(MAX_OUT);
   assign cmd_ready = !want_hold && (!any_flag || room);
   assign accept    = cmd_valid && cmd_ready;
   assign hold_o    = want_hold ? (NSTAGE'(1) << first_idx) : '0;

   // ---------------- pending draws, oldest first ----------------
   coh_fifo #(.W(SIDX_W), .DEPTH(MAX_OUT)) u_draws (
      .clk   (clk),
      .rst   (rst),
      .push  (accept && any_flag),
      .din   (last_idx),
      .pop   (done_hit),
      .dout  (head_stage),
      .count (draw_cnt),
      .empty (draw_empty)
   );

   assign done_hit = !draw_empty && stage_done[head_stage];

   // ---------------- flush issue and acknowledgement ----------------
   coh_flush_queue #(.DEPTH(MAX_OUT), .SW(SIDX_W)) u_flush (
      .clk        (clk),
      .rst        (rst),
      .push       (done_hit),
      .push_stage (head_stage),
      .out_valid  (flush_valid),
      .out_ready  (flush_ready),
      .out_stage  (flush_stage),
      .ack        (flush_ack),
      .ack_take   (ack_take),
      .ack_stage  (ack_stage),
      .count      (fq_cnt)
   );

   assign spurious = flush_ack && !ack_take;

   // ---------------- per-stage semaphores ----------------
   for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
      assign inc_v[s] = accept && (|(cmd_uav >> s));
      assign dec_v[s] = ack_take && (ack_stage >= SIDX_W'(s));

      coh_sem_cell #(.W(CNT_W)) u_cell (
         .clk (clk),
         .rst (rst),
         .inc (inc_v[s]),
         .dec (dec_v[s]),
         .cnt (sem[s]),
         .ovf (ovf_v[s]),
         .unf (unf_v[s])
      );

      assign sem_o[s*CNT_W +: CNT_W] = sem[s];
   end

   // ---------------- sticky error ----------------
   always_ff @(posedge clk) begin
      if (rst)
         err_o <= 1'b0;
      else if (spurious || (|ovf_v) || (|unf_v))
         err_o <= 1'b1;
   end

   AST_HOLD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hold_o)); // R7
   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      hold_o != '0 |-> !cmd_ready); // R7
   AST_OCC_LIMIT: assert property (@(posedge clk) disable iff (rst)
      occ <= OSW'(MAX_OUT)); // R8
   AST_NOFLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
      accept && !any_flag && !flush_ack |=> $stable(sem_o)); // R3
   AST_DONE_FLUSH: assert property (@(posedge clk) disable iff (rst)
      done_hit |=> flush_valid); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
      err_o |=> err_o); // R9

endmodule

// File: tb/sim_coh_sem_tracker.sv
module sim_coh_sem_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [4:0]  cmd_uav = '0;
   logic        cmd_coh = 1'b0;
   logic [4:0]  stage_done = '0;
   logic [4:0]  hold_o;
   logic        flush_valid;
   logic        flush_ready = 1'b0;
   logic [2:0]  flush_stage;
   logic        flush_ack = 1'b0;
   logic [5*CW-1:0] sem_o;
   logic        err_o;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   coh_sem_tracker u0 (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_uav(cmd_uav), .cmd_coh(cmd_coh), .stage_done(stage_done),
      .hold_o(hold_o), .flush_valid(flush_valid), .flush_ready(flush_ready),
      .flush_stage(flush_stage), .flush_ack(flush_ack), .sem_o(sem_o),
      .err_o(err_o)
   );

   // {flags, stages expected to read 1, flush stage, flush expected}
   localparam logic [13:0] VEC [0:7] = '{
      {5'b00001, 5'b00001, 3'd0, 1'b1},
      {5'b00010, 5'b00011, 3'd1, 1'b1},
      {5'b00100, 5'b00111, 3'd2, 1'b1},
      {5'b01000, 5'b01111, 3'd3, 1'b1},
      {5'b10000, 5'b11111, 3'd4, 1'b1},
      {5'b10001, 5'b11111, 3'd4, 1'b1},
      {5'b00101, 5'b00111, 3'd2, 1'b1},
      {5'b00000, 5'b00000, 3'd0, 1'b0}
   };

   function automatic logic [7:0] sem_of(input int s);
      return sem_o[s*CW +: CW];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_sems(input string req, input logic [7:0] e0, input logic [7:0] e1,
                             input logic [7:0] e2, input logic [7:0] e3, input logic [7:0] e4);
      check(req, {sem_of(4), sem_of(3), sem_of(2), sem_of(1), sem_of(0)},
            {e4, e3, e2, e1, e0});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic send(input logic [4:0] f, input logic c);
      cmd_uav = f; cmd_coh = c; cmd_valid = 1'b1;
      #1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_uav = '0; cmd_coh = 1'b0;
   endtask

   task automatic pulse_done(input logic [4:0] m, input int cycles);
      stage_done = m;
      repeat (cycles) @(negedge clk);
      stage_done = '0;
   endtask

   task automatic take_flush(input int cycles);
      flush_ready = 1'b1;
      repeat (cycles) @(negedge clk);
      flush_ready = 1'b0;
   endtask

   task automatic give_ack();
      flush_ack = 1'b1;
      @(negedge clk);
      flush_ack = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 sems", sem_o, '0);
      check("R1 flush_valid", flush_valid, 0);
      check("R1 err", err_o, 0);
      check("R1 hold", hold_o, 0);
      check("R1 ready", cmd_ready, 1);

      // table walk: R2 counting, R4 flush stage, R5 release, R3 no-flag draw
      for (int i = 0; i < 8; i++) begin
         logic [4:0] f, m;
         logic [2:0] st;
         logic       fl;
         {f, m, st, fl} = VEC[i];
         send(f, 1'b0);
         for (int s = 0; s < 5; s++)
            check("R2 count after accept", sem_of(s), {7'd0, m[s]});
         if (fl) begin
            pulse_done(~(5'b1 << st), 1);
            check("R4 other stage ignored", flush_valid, 0);
            pulse_done(5'b1 << st, 1);
            check("R4 flush raised", flush_valid, 1);
            check("R4 flush stage", flush_stage, st);
            take_flush(1);
            check("R4 flush taken", flush_valid, 0);
            give_ack();
            check("R5 release after ack", sem_o, '0);
         end else begin
            pulse_done(5'b11111, 1);
            check("R3 no flush", flush_valid, 0);
            check("R3 no count", sem_o, '0);
         end
      end

      // R7 ordering hold
      send(5'b00010, 1'b0);
      cmd_uav = 5'b00110; cmd_coh = 1'b1; cmd_valid = 1'b1;
      #1;
      check("R7 hold onehot", hold_o, 5'b00010);
      check("R7 ready low", cmd_ready, 0);
      @(negedge clk);
      check("R7 still held", hold_o, 5'b00010);
      pulse_done(5'b00010, 1);
      take_flush(1);
      check("R7 held until ack", cmd_ready, 0);
      give_ack();
      check("R7 released", cmd_ready, 1);
      check("R7 hold cleared", hold_o, 0);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_coh = 1'b0; cmd_uav = '0;
      check_sems("R7 accepted after drain", 1, 1, 1, 0, 0);
      pulse_done(5'b00100, 1);
      take_flush(1);
      give_ack();
      // R7 no hold without ordering bit
      send(5'b00001, 1'b0);
      cmd_uav = 5'b00001; cmd_coh = 1'b0; cmd_valid = 1'b1;
      #1;
      check("R7 no hold when bit clear", hold_o, 0);
      check("R7 ready when bit clear", cmd_ready, 1);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_uav = '0;
      check_sems("R7 counted", 2, 0, 0, 0, 0);
      pulse_done(5'b00001, 2);
      take_flush(2);
      give_ack();
      give_ack();
      check("R7 drained", sem_o, '0);

      // R8 occupancy limit
      for (int k = 0; k < 4; k++) send(5'b00001, 1'b0);
      check_sems("R8 four in flight", 4, 0, 0, 0, 0);
      cmd_uav = 5'b00001; cmd_valid = 1'b1;
      #1;
      check("R8 ready low at limit", cmd_ready, 0);
      cmd_uav = 5'b00000;
      #1;
      check("R8 unflagged still taken", cmd_ready, 1);
      cmd_valid = 1'b0;
      pulse_done(5'b00001, 1);
      cmd_uav = 5'b00001; cmd_valid = 1'b1;
      #1;
      check("R8 flush still counts", cmd_ready, 0);
      cmd_valid = 1'b0; cmd_uav = '0;
      take_flush(1);
      give_ack();
      cmd_uav = 5'b00001; cmd_valid = 1'b1;
      #1;
      check("R8 room after ack", cmd_ready, 1);
      cmd_valid = 1'b0; cmd_uav = '0;

      // R6 back-to-back completions, vertex only
      pulse_done(5'b00001, 2);
      check("R6 first flush", flush_valid, 1);
      take_flush(1);
      check("R6 second flush present", flush_valid, 1);
      take_flush(1);
      check("R6 both taken", flush_valid, 0);
      give_ack();
      give_ack();
      check_sems("R6 two released", 1, 0, 0, 0, 0);
      pulse_done(5'b00001, 1);
      take_flush(1);
      give_ack();
      check("R6 drained", sem_o, '0);
      check("R9 no error so far", err_o, 0);

      // R10 order and steadiness
      send(5'b00100, 1'b0);
      send(5'b10000, 1'b0);
      check_sems("R10 counts", 2, 2, 2, 1, 1);
      pulse_done(5'b00100, 1);
      repeat (3) @(negedge clk);
      check("R10 valid steady", flush_valid, 1);
      check("R10 stage steady", flush_stage, 2);
      pulse_done(5'b10000, 1);
      check("R10 oldest first", flush_stage, 2);
      take_flush(1);
      check("R10 next in order", flush_stage, 4);
      take_flush(1);
      give_ack();
      check_sems("R10 partial release", 1, 1, 1, 1, 1);
      give_ack();
      check("R10 drained", sem_o, '0);

      // R9 spurious acknowledgement
      give_ack();
      check("R9 error set", err_o, 1);
      repeat (2) @(negedge clk);
      check("R9 error sticky", err_o, 1);
      do_reset();
      check("R9 cleared by reset", err_o, 0);
      check("R1 sems after reset", sem_o, '0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule